// File: doc/BRIEF.md
# External Interrupt Sense and Mask Controller

This block takes up to 32 asynchronous interrupt lines from outside the chip and presents one interrupt output per line to the CPU. Each line is passed through a synchroniser. It is then judged against its own sense mode, which is one of: level high, level low, rising edge, falling edge, or either edge. A detected event is held in a per-line detect bit, and a per-line enable decides whether that bit reaches the CPU output.

Software reaches the block over a flat 32-bit register bus with a single-cycle write strobe and combinational read data. Enables are changed through separate write-one-to-set and write-one-to-clear offsets, so a driver never needs a read-modify-write. Latched edge events are acknowledged by writing ones to the detect word. Every line has its own configuration word that holds a 6-bit sense code.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every enable, every detect bit and every sense field reads zero, and `cpu_irq` is all zero.
- R2: Each input goes through two synchronising flops and one history flop. A change driven just after a clock edge shows on `cpu_irq` after the third following rising edge, and not after the second.
- R3: With sense code 0x08, a 0-to-1 transition of the synchronised input sets the detect bit. The bit stays set while the input remains high.
- R4: Sense code 0x04 latches 1-to-0 transitions. Sense code 0x0C latches transitions in both directions.
- R5: Sense codes 0x02 (high) and 0x01 (low) make the detect bit follow the active level one cycle after synchronisation. Writing one to the detect word does not clear the bit while the level is still active.
- R6: Any sense code other than 0x01, 0x02, 0x04, 0x08 or 0x0C detects nothing. A detect bit that is already set holds until it is cleared by a write.
- R7: Writing to offset 0x08 enables every channel whose data bit is 1 and leaves the other channels unchanged. Reads at 0x04 and 0x08 return the enable mask, with bit n for channel n.
- R8: Writing to offset 0x04 disables every channel whose data bit is 1 and leaves the other channels unchanged.
- R9: Offset 0x100 reads the detect word, with bit n for channel n. Writing ones there clears the matching edge-mode detect bits.
- R10: `cpu_irq[n]` is high exactly when detect bit n and enable bit n are both set. Offset 0x00 reads this same masked word.
- R11: The configuration word for channel n sits at 0x180 + 4*n. It keeps bits [5:0] of a write, and the upper bits read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | NUM_CH | Asynchronous external interrupt lines |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| cpu_irq | output | NUM_CH | Per-channel masked interrupt toward the CPU |

## Verification
A corrupted history flop or sense decode shows up as a spurious or missing detect bit on the 0x100 read, and as a wrong `cpu_irq` three clocks after the offending input change. A corrupted enable register shows up at once on the 0x04 readback, and on `cpu_irq` in the same cycle that the detect bit is set. A level-mode channel that latches instead of following its level keeps its detect bit set after the input returns idle. The bench catches that on the next read of 0x100.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned SNS_W = 6;

  localparam logic [SNS_W-1:0] SNS_LOW  = 6'h01;
  localparam logic [SNS_W-1:0] SNS_HIGH = 6'h02;
  localparam logic [SNS_W-1:0] SNS_FALL = 6'h04;
  localparam logic [SNS_W-1:0] SNS_RISE = 6'h08;
  localparam logic [SNS_W-1:0] SNS_BOTH = 6'h0C;

  localparam int unsigned OFS_PEND   = 32'h000;
  localparam int unsigned OFS_EN_CLR = 32'h004;
  localparam int unsigned OFS_EN_SET = 32'h008;
  localparam int unsigned OFS_DET    = 32'h100;
  localparam int unsigned OFS_CFG    = 32'h180;

  function automatic logic sense_valid(input logic [SNS_W-1:0] s);
    return (s == SNS_LOW) || (s == SNS_HIGH) || (s == SNS_FALL) ||
           (s == SNS_RISE) || (s == SNS_BOTH);
  endfunction
endpackage

// File: rtl/eic_rst_sync.sv
module eic_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_in;
      stab_q <= meta_q;
    end
  end

  assign sync_out = stab_q;
endmodule

// File: rtl/eic_detect.sv
module eic_detect
  import eic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SNS_W-1:0] sense,
  input  logic             lvl,
  input  logic             clr,
  output logic             det
);
  logic prev_q;
  logic det_q, det_d;
  logic rise, fall, held;

  always_comb begin
    rise = lvl & ~prev_q;
    fall = ~lvl & prev_q;
    held = det_q & ~clr;
    unique case (sense)
      SNS_LOW:  det_d = ~lvl;
      SNS_HIGH: det_d = lvl;
      SNS_FALL: det_d = fall | held;
      SNS_RISE: det_d = rise | held;
      SNS_BOTH: det_d = rise | fall | held;
      default:  det_d = held;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      det_q  <= 1'b0;
    end else begin
      prev_q <= lvl;
      det_q  <= det_d;
    end
  end

  assign det = det_q;

  p_rise_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sense == SNS_RISE && lvl && !prev_q) |=> det_q);

  p_fall_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sense == SNS_FALL && !lvl && prev_q) |=> det_q);

  p_level_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sense == SNS_HIGH) |=> (det_q == $past(lvl)));

  p_bad_code_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sense_valid(sense) && !det_q) |=> !det_q);
endmodule

// File: rtl/eic_regs.sv
module eic_regs
  import eic_pkg::*;
#(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [NUM_CH-1:0] det_vec,
  output logic [NUM_CH-1:0] en_vec,
  output logic [NUM_CH-1:0] clr_vec,
  output logic [SNS_W-1:0]  sense_arr [NUM_CH],
  output logic [BUS_W-1:0]  bus_rdata
);
  localparam logic [ADDR_W-1:0] A_PEND   = ADDR_W'(OFS_PEND);
  localparam logic [ADDR_W-1:0] A_EN_CLR = ADDR_W'(OFS_EN_CLR);
  localparam logic [ADDR_W-1:0] A_EN_SET = ADDR_W'(OFS_EN_SET);
  localparam logic [ADDR_W-1:0] A_DET    = ADDR_W'(OFS_DET);
  localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(OFS_CFG);
  localparam int unsigned       IDX_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_CH-1:0] wdata_ch;
  logic [NUM_CH-1:0] en_q, en_d;
  logic              en_we;
  logic              cfg_hit;
  logic [ADDR_W-1:0] cfg_ofs;
  logic [IDX_W-1:0]  cfg_idx;
  logic [SNS_W-1:0]  cfg_q [NUM_CH];

  assign wdata_ch = bus_wdata[NUM_CH-1:0];

  // enable mask: set and clear through separate offsets
  always_comb begin
    en_d  = en_q;
    en_we = 1'b0;
    if (bus_wr && bus_addr == A_EN_SET) begin
      en_d  = en_q | wdata_ch;
      en_we = 1'b1;
    end else if (bus_wr && bus_addr == A_EN_CLR) begin
      en_d  = en_q & ~wdata_ch;
      en_we = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_d;
  end

  assign clr_vec = (bus_wr && bus_addr == A_DET) ? wdata_ch : '0;

  // configuration words
  always_comb begin
    cfg_ofs = bus_addr - A_CFG;
    cfg_hit = (bus_addr >= A_CFG) && (bus_addr[1:0] == 2'b00) &&
              (int'(cfg_ofs >> 2) < int'(NUM_CH));
    cfg_idx = IDX_W'(cfg_ofs >> 2);
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cfg
    logic             cfg_we;
    logic [SNS_W-1:0] cfg_d;

    always_comb begin
      cfg_we = bus_wr && cfg_hit && (int'(cfg_idx) == g);
      cfg_d  = bus_wdata[SNS_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q[g] <= '0;
      else if (cfg_we) cfg_q[g] <= cfg_d;
    end

    assign sense_arr[g] = cfg_q[g];
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_PEND)
      bus_rdata[NUM_CH-1:0] = det_vec & en_q;
    else if (bus_addr == A_EN_CLR || bus_addr == A_EN_SET)
      bus_rdata[NUM_CH-1:0] = en_q;
    else if (bus_addr == A_DET)
      bus_rdata[NUM_CH-1:0] = det_vec;
    else if (cfg_hit)
      bus_rdata[SNS_W-1:0] = cfg_q[cfg_idx];
  end

  assign en_vec = en_q;

  p_set_only_raises_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_EN_SET) |=>
      (((en_q & $past(wdata_ch)) == $past(wdata_ch)) &&
       ((en_q & ~$past(wdata_ch)) == ($past(en_q) & ~$past(wdata_ch)))));

  p_clear_only_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_EN_CLR) |=>
      (((en_q & $past(wdata_ch)) == '0) &&
       ((en_q & ~$past(wdata_ch)) == ($past(en_q) & ~$past(wdata_ch)))));

  p_no_write_keeps_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr) |=> $stable(en_q));
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eic_pkg::*;
#(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] irq_in,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] cpu_irq
);
  logic              rst_int_n;
  logic [NUM_CH-1:0] lvl_vec;
  logic [NUM_CH-1:0] det_vec;
  logic [NUM_CH-1:0] en_vec;
  logic [NUM_CH-1:0] clr_vec;
  logic [SNS_W-1:0]  sense_arr [NUM_CH];

  eic_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_int_n)
  );

  eic_sync #(.W(NUM_CH)) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .async_in (irq_in),
    .sync_out (lvl_vec)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    eic_detect u_det (
      .clk   (clk),
      .rst_n (rst_int_n),
      .sense (sense_arr[c]),
      .lvl   (lvl_vec[c]),
      .clr   (clr_vec[c]),
      .det   (det_vec[c])
    );
  end

  eic_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .det_vec   (det_vec),
    .en_vec    (en_vec),
    .clr_vec   (clr_vec),
    .sense_arr (sense_arr),
    .bus_rdata (bus_rdata)
  );

  assign cpu_irq = det_vec & en_vec;

  p_disable_silences_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_EN_CLR)) |=>
      ((cpu_irq & $past(bus_wdata[NUM_CH-1:0])) == '0));
endmodule

// File: tb/ext_irq_ctrl_test.sv
module ext_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 32;

  typedef struct {
    int          kind;   // 0: bus_rdata, 1: cpu_irq
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NCH-1:0]  irq_in;
  logic            bus_wr;
  logic [8:0]      bus_addr;
  logic [31:0]     bus_wdata;
  logic [31:0]     bus_rdata;
  logic [NCH-1:0]  cpu_irq;

  item_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  ext_irq_ctrl #(.NUM_CH(NCH), .ADDR_W(9)) uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_irq(cpu_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: pops expectations and compares
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        act = (it.kind == 0) ? bus_rdata : cpu_irq;
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic exp_rd(input logic [8:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a;
    it.kind = 0; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic exp_irq(input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    it.kind = 1; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    @(negedge clk);
    #3;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; irq_in = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    settle(3);
    @(negedge clk) rst_n = 1'b1;
    settle(4);

    // R1 reset state
    exp_rd(9'h004, 32'h0, "R1 enable after reset");
    exp_rd(9'h100, 32'h0, "R1 detect after reset");
    exp_rd(9'h180, 32'h0, "R1 cfg0 after reset");
    exp_irq(32'h0, "R1 cpu_irq after reset");

    // R7 enable set, zero bits ignored; R11 rising config on ch0
    wr(9'h180, 32'h08);
    wr(9'h008, 32'h1);
    exp_rd(9'h004, 32'h1, "R7 enable mask via 0x04");
    wr(9'h008, 32'h0);
    exp_rd(9'h008, 32'h1, "R7 zero write keeps mask");

    // R2 latency and R3 rising edge
    irq_in[0] = 1'b1;
    settle(2);
    exp_irq(32'h0, "R2 not yet after two edges");
    exp_irq(32'h1, "R2 R3 visible after third edge");
    exp_rd(9'h100, 32'h1, "R3 detect bit0");
    exp_rd(9'h000, 32'h1, "R10 pending word");
    // R9 write one clears, input still high, no re-trigger
    wr(9'h100, 32'h1);
    settle(3);
    exp_rd(9'h100, 32'h0, "R9 W1C edge bit");
    exp_irq(32'h0, "R9 cpu_irq after clear");

    // R4 falling on ch1, masked; R10 and R8
    wr(9'h184, 32'h04);
    irq_in[1] = 1'b1;
    settle(5);
    exp_rd(9'h100, 32'h0, "R4 rising ignored in falling mode");
    irq_in[1] = 1'b0;
    settle(5);
    exp_rd(9'h100, 32'h2, "R4 falling latched");
    exp_rd(9'h000, 32'h0, "R10 masked pending");
    exp_irq(32'h0, "R10 masked output");
    wr(9'h008, 32'h2);
    exp_irq(32'h2, "R10 enabled output");
    wr(9'h004, 32'h2);
    exp_irq(32'h0, "R8 disabled output");
    exp_rd(9'h004, 32'h1, "R8 other enables kept");
    wr(9'h100, 32'hFFFF_FFFF);

    // R4 both edges on ch2
    wr(9'h188, 32'h0C);
    irq_in[2] = 1'b1;
    settle(5);
    exp_rd(9'h100, 32'h4, "R4 both: rise");
    wr(9'h100, 32'h4);
    exp_rd(9'h100, 32'h0, "R9 clear both-mode");
    irq_in[2] = 1'b0;
    settle(5);
    exp_rd(9'h100, 32'h4, "R4 both: fall");
    wr(9'h100, 32'hFFFF_FFFF);

    // R5 level high on ch3
    wr(9'h18C, 32'h02);
    irq_in[3] = 1'b1;
    settle(5);
    exp_rd(9'h100, 32'h8, "R5 level high active");
    wr(9'h100, 32'h8);
    exp_rd(9'h100, 32'h8, "R5 W1C no effect while active");
    irq_in[3] = 1'b0;
    settle(5);
    exp_rd(9'h100, 32'h0, "R5 level high released");

    // R5 level low on ch4
    wr(9'h190, 32'h01);
    settle(2);
    exp_rd(9'h100, 32'h10, "R5 level low active");
    irq_in[4] = 1'b1;
    settle(5);
    exp_rd(9'h100, 32'h0, "R5 level low released");
    irq_in[4] = 1'b0;
    settle(5);
    wr(9'h190, 32'h00);
    exp_rd(9'h100, 32'h10, "R6 bad code holds bit");
    wr(9'h100, 32'hFFFF_FFFF);
    exp_rd(9'h100, 32'h0, "R6 held bit cleared");

    // R6 and R11 on ch5
    wr(9'h194, 32'hFF);
    exp_rd(9'h194, 32'h3F, "R11 six-bit field");
    wr(9'h008, 32'h20);
    irq_in[5] = 1'b1;
    settle(5);
    irq_in[5] = 1'b0;
    settle(5);
    exp_rd(9'h100, 32'h0, "R6 bad code detects nothing");
    exp_irq(32'h0, "R6 no output");

    // top channel
    wr(9'h1FC, 32'h08);
    exp_rd(9'h1FC, 32'h08, "R11 cfg31 address");
    wr(9'h008, 32'h8000_0000);
    irq_in[31] = 1'b1;
    settle(2);
    exp_irq(32'h0, "R2 ch31 not yet");
    exp_irq(32'h8000_0000, "R3 ch31 edge");
    exp_rd(9'h004, 32'h8000_0021, "R7 accumulated mask");
    exp_rd(9'h000, 32'h8000_0000, "R10 pending ch31");

    done = 1'b1;
    finish_run();
  end
endmodule